// File: doc/BRIEF.md
# SMBus Register-Pointer Slave Interface

This block is the slave side of a two-wire SMBus/I2C link. It samples the clock and data lines in the system clock domain, finds START and STOP conditions, and recognises its own 7-bit bus address. The upper address bits are a build parameter and the lower three come from strap inputs. It acknowledges by pulling the data line low and returns read data the same way, as an open-drain output.

A host reaches a small bank of 8-bit registers through a command-byte pointer. Three transaction forms are handled:
- **Write byte:** address with write, command, data. The data byte is written to the register that the command names.
- **Read byte:** address with write, command, repeated START, address with read, then one data byte out.
- **Receive byte:** address with read, then one data byte out from the register named by the most recent acknowledged command.

The register bank sits outside the block and is reached through a simple synchronous port. Read data is expected one clock after the read strobe.

Top module: `smb_regptr_slave`

## Requirements
- R1: Before any START condition (SDA falling while SCL is high) the block ignores all bus activity: it never pulls SDA and never strobes the register port.
- R2: A STOP condition (SDA rising while SCL is high) ends any transaction and returns the block to idle, where clocked bits are ignored until the next START.
- R3: The first byte after START is the address byte: 7 address bits MSB first, then the R/W bit (1 = read). The block pulls SDA low during the ninth clock only if the 7 bits equal {ADDR_BASE[6:3], strap_i[2:0]} (default upper bits 4'b1001).
- R4: In a write byte, the command byte and the data byte are each acknowledged, and exactly one single-cycle write strobe is issued, with address equal to the command byte and data equal to the data byte. The read strobe and the write strobe are never active together.
- R5: In a read byte, after a repeated START and the address with R=1, the block sends the 8 bits of the register named by the command byte, MSB first.
- R6: A receive byte returns the register named by the most recent acknowledged command byte. After reset the pointer is 0.
- R7: After the eighth bit it sends, the block releases SDA and keeps it released, whatever the host answers, until the next START or STOP.
- R8: On an address mismatch the block stays released until the next START and makes no register access.
- R9: A repeated START at any point, even in the middle of a byte, restarts address reception.
- R10: The block changes its SDA drive only while SCL is low.
- R11: The command pointer changes only when a command byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| strap_i | input | 3 | Low address bits from strap pins |
| reg_addr_o | output | 8 | Register index, equal to the command pointer |
| reg_wdata_o | output | 8 | Write data to the register bank |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe; data is expected on the next clock |
| reg_rdata_i | input | 8 | Read data from the register bank |

## Verification
Address recognition is checked with a sweep over all 128 address values under one strap setting. Every strap setting is then tried against its matching address and against a neighbour that differs only in a strap bit, which separates the parameter bits from the strap bits. Each of eight registers is written with a distinct, arithmetically derived pattern and read back with read byte, so bit order and index decoding both show up. Receive-byte runs after resets, reads, writes and rejected transactions show whether the pointer moves only on acknowledged commands. A repeated START mid-byte, bus clocking after STOP or before any START, and extra clocks after a host NACK test the idle and released cases.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int ADDR_BITS = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_ACK, ST_TX, ST_HOLD
  } smb_state_e;

  // Address byte carries the 7-bit target in its upper bits.
  function automatic logic addr_hit(input logic [7:0] abyte,
                                    input logic [ADDR_BITS-1:0] mine);
    return abyte[7:1] == mine;
  endfunction

  function automatic logic is_read(input logic [7:0] abyte);
    return abyte[0];
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  // Bus idles high, so reset to 1 to avoid a phantom edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_rx_shifter.sv
module smb_rx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  logic [CNT_W-1:0] cnt;

  assign full_o = (cnt == CNT_W'(DATA_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      byte_o <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (shift_en && !full_o) begin
      byte_o <= {byte_o[DATA_W-2:0], bit_i};
      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/smb_regptr_slave.sv
module smb_regptr_slave
  import smb_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE   = 7'h48,
  parameter int         STRAP_W     = 3,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [DATA_W-1:0]  reg_addr_o,
  output logic [DATA_W-1:0]  reg_wdata_o,
  output logic               reg_we_o,
  output logic               reg_re_o,
  input  logic [DATA_W-1:0]  reg_rdata_i
);
  localparam int TXC_W = $clog2(DATA_W);

  // Synchronisers: index 1 = SCL, index 0 = SDA
  logic [1:0] raw_lines, synced;
  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_lines[g]), .q_o(synced[g])
    );
  end

  logic scl_s, sda_s;
  assign scl_s = synced[1];
  assign sda_s = synced[0];

  // Named bus events
  logic scl_rise, scl_fall, start_ev, stop_ev;
  smb_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  smb_state_e state, ack_next;
  logic [DATA_W-1:0] rx_byte, tx_sh, cmd_ptr;
  logic              rx_full, rx_clr, rd_pend;
  logic [TXC_W-1:0]  tx_cnt;
  logic [ADDR_BITS-1:0] my_addr;

  assign my_addr = {ADDR_BASE[ADDR_BITS-1:STRAP_W], strap_i};
  assign rx_clr  = start_ev | (state == ST_ACK && scl_fall);

  smb_rx_shifter #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .shift_en(scl_rise),
    .bit_i(sda_s), .byte_o(rx_byte), .full_o(rx_full)
  );

  // Named internal events for the checker
  logic byte_end, cmd_take, in_idle, in_hold, in_addr;
  assign byte_end = scl_fall & rx_full;
  assign cmd_take = (state == ST_CMD) & byte_end;
  assign in_idle  = (state == ST_IDLE);
  assign in_hold  = (state == ST_HOLD);
  assign in_addr  = (state == ST_ADDR);

  assign reg_addr_o = cmd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      ack_next    <= ST_IDLE;
      sda_pull_o  <= 1'b0;
      cmd_ptr     <= '0;
      reg_wdata_o <= '0;
      reg_we_o    <= 1'b0;
      reg_re_o    <= 1'b0;
      rd_pend     <= 1'b0;
      tx_sh       <= '0;
      tx_cnt      <= '0;
    end else begin
      reg_we_o <= 1'b0;
      reg_re_o <= 1'b0;
      rd_pend  <= reg_re_o;
      if (rd_pend) tx_sh <= reg_rdata_i;

      if (stop_ev) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else if (start_ev) begin
        state      <= ST_ADDR;
        sda_pull_o <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (byte_end) begin
            if (addr_hit(rx_byte, my_addr)) begin
              sda_pull_o <= 1'b1;
              state      <= ST_ACK;
              if (is_read(rx_byte)) begin
                ack_next <= ST_TX;
                reg_re_o <= 1'b1;
              end else begin
                ack_next <= ST_CMD;
              end
            end else begin
              state <= ST_HOLD;
            end
          end
          ST_CMD: if (byte_end) begin
            cmd_ptr    <= rx_byte;
            sda_pull_o <= 1'b1;
            ack_next   <= ST_WDATA;
            state      <= ST_ACK;
          end
          ST_WDATA: if (byte_end) begin
            reg_we_o    <= 1'b1;
            reg_wdata_o <= rx_byte;
            sda_pull_o  <= 1'b1;
            ack_next    <= ST_HOLD;
            state       <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            state  <= ack_next;
            tx_cnt <= '0;
            if (ack_next == ST_TX) sda_pull_o <= ~tx_sh[DATA_W-1];
            else                   sda_pull_o <= 1'b0;
          end
          ST_TX: if (scl_fall) begin
            if (tx_cnt == TXC_W'(DATA_W - 1)) begin
              sda_pull_o <= 1'b0;
              state      <= ST_HOLD;
            end else begin
              tx_sh      <= {tx_sh[DATA_W-2:0], 1'b0};
              sda_pull_o <= ~tx_sh[DATA_W-2];
              tx_cnt     <= tx_cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_regptr_slave_chk.sv
module smb_regptr_slave_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_pull_o,
  input logic              reg_we_o,
  input logic              reg_re_o,
  input logic [DATA_W-1:0] reg_addr_o,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              cmd_take,
  input logic              in_idle,
  input logic              in_hold,
  input logic              in_addr
);
  // R10
  pull_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_s));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> (!sda_pull_o && !reg_we_o && !reg_re_o));
  // R2
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> in_idle);
  // R4
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);
  // R4
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_o && reg_re_o));
  // R11
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_o != $past(reg_addr_o)) |-> $past(cmd_take));
  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |-> !sda_pull_o);
  // R9
  start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> in_addr);
endmodule

bind smb_regptr_slave smb_regptr_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull_o(sda_pull_o),
  .reg_we_o(reg_we_o), .reg_re_o(reg_re_o), .reg_addr_o(reg_addr_o),
  .start_ev(start_ev), .stop_ev(stop_ev), .cmd_take(cmd_take),
  .in_idle(in_idle), .in_hold(in_hold), .in_addr(in_addr)
);

// File: tb/test_smb_regptr_slave.sv
`timescale 1ns/1ps
module test_smb_regptr_slave;
  localparam int Q = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, host_pull = 1'b0;
  logic slv_pull, sda_bus;
  logic [2:0] strap = 3'd5;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic reg_we, reg_re;
  int checks = 0, errors = 0, we_cnt = 0, cyc = 0;
  logic [7:0] mem [8];
  logic [7:0] expv [8];

  always #4 clk = ~clk;
  assign sda_bus = ~(host_pull | slv_pull);

  smb_regptr_slave i_smb_regptr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(slv_pull), .strap_i(strap), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_re_o(reg_re),
    .reg_rdata_i(reg_rdata)
  );

  // Bench register bank: synchronous read, one clock latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mem[i] <= 8'hA0 + 8'(i);
      reg_rdata <= '0;
    end else begin
      if (reg_we) begin
        mem[reg_addr[2:0]] <= reg_wdata;
        we_cnt <= we_cnt + 1;
      end
      if (reg_re) reg_rdata <= mem[reg_addr[2:0]];
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    host_pull = 1'b0; wt(Q); scl = 1'b1; wt(Q);
    host_pull = 1'b1; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic do_stop();
    host_pull = 1'b1; wt(Q); scl = 1'b1; wt(Q);
    host_pull = 1'b0; wt(2*Q);
  endtask

  task automatic send_bit(input bit b);
    host_pull = ~b; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    host_pull = 1'b0; wt(Q); scl = 1'b1; wt(Q);
    ack = ~sda_bus; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(output logic [7:0] d, output bit rel);
    host_pull = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl = 1'b1; wt(Q); d[i] = sda_bus; wt(Q); scl = 1'b0; wt(Q);
    end
    wt(Q); scl = 1'b1; wt(Q); rel = sda_bus; wt(Q); scl = 1'b0; wt(Q);
  endtask

  function automatic logic [6:0] my_addr(input logic [2:0] s);
    return {4'b1001, s};
  endfunction

  function automatic logic [7:0] pattern(input int i);
    return 8'((i * 29 + 7) ^ 8'h5A);
  endfunction

  task automatic write_reg(input logic [6:0] a, input logic [7:0] c,
                           input logic [7:0] d, output bit ok);
    bit k0, k1, k2;
    do_start(); send_byte({a, 1'b0}, k0); send_byte(c, k1); send_byte(d, k2);
    do_stop(); ok = k0 & k1 & k2;
  endtask

  task automatic read_reg(input logic [6:0] a, input logic [7:0] c,
                          output logic [7:0] d, output bit ok, output bit rel);
    bit k0, k1, k2;
    do_start(); send_byte({a, 1'b0}, k0); send_byte(c, k1);
    do_start(); send_byte({a, 1'b1}, k2); recv_byte(d, rel);
    do_stop(); ok = k0 & k1 & k2;
  endtask

  task automatic recv_only(input logic [6:0] a, output logic [7:0] d,
                           output bit ok, output bit rel);
    do_start(); send_byte({a, 1'b1}, ok); recv_byte(d, rel); do_stop();
  endtask

  initial begin
    logic [7:0] d;
    bit ok, rel, ack;
    int w0;
    for (int i = 0; i < 8; i++) expv[i] = 8'hA0 + 8'(i);
    wt(5);
    chk(slv_pull == 1'b0 && reg_we == 1'b0 && reg_re == 1'b0, "reset state",
        {slv_pull, reg_we, reg_re}, 0);
    rst_n = 1'b1; wt(5);

    // R1: bits clocked before any START are ignored
    send_byte({my_addr(strap), 1'b0}, ack);
    chk(ack == 1'b0, "R1 no ack before START", ack, 0);
    send_byte(8'h02, ack);
    chk(ack == 1'b0 && we_cnt == 0, "R1 no access before START", we_cnt, 0);
    do_stop();

    // R6: pointer is 0 after reset
    recv_only(my_addr(strap), d, ok, rel);
    chk(ok, "R3 ack on own address (read)", ok, 1);
    chk(d == expv[0], "R6 receive after reset reads reg 0", d, expv[0]);

    // R3: sweep all addresses with one strap setting
    for (int a = 0; a < 128; a++) begin
      do_start(); send_byte({7'(a), 1'b0}, ack); do_stop();
      chk(ack == (7'(a) == my_addr(strap)), "R3 address sweep", {a, ack},
          {a, 7'(a) == my_addr(strap)});
    end
    // R3: each strap setting vs a neighbour differing in one strap bit
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      do_start(); send_byte({my_addr(3'(s)), 1'b0}, ack); do_stop();
      chk(ack == 1'b1, "R3 strap match", s, 1);
      do_start(); send_byte({my_addr(3'(s ^ (1 << (s % 3)))), 1'b0}, ack); do_stop();
      chk(ack == 1'b0, "R3 strap neighbour rejected", s, 0);
    end
    strap = 3'd5;

    // R4: write byte to every register
    for (int i = 0; i < 8; i++) begin
      w0 = we_cnt;
      write_reg(my_addr(strap), 8'(i), pattern(i), ok);
      expv[i] = pattern(i);
      chk(ok, "R4 write byte acks", ok, 1);
      chk(we_cnt == w0 + 1, "R4 one write strobe", we_cnt - w0, 1);
    end
    // R5, R7: read byte returns each register MSB first, then releases
    for (int i = 7; i >= 0; i--) begin
      read_reg(my_addr(strap), 8'(i), d, ok, rel);
      chk(ok && d == expv[i], "R5 read byte value", d, expv[i]);
      chk(rel == 1'b1, "R7 released in ninth clock", rel, 1);
    end

    // R6: receive byte follows last read-byte command
    read_reg(my_addr(strap), 8'd3, d, ok, rel);
    recv_only(my_addr(strap), d, ok, rel);
    chk(ok && d == expv[3], "R6 receive after read of reg 3", d, expv[3]);
    // R6: receive byte follows last write-byte command
    write_reg(my_addr(strap), 8'd6, 8'h96, ok);
    expv[6] = 8'h96;
    recv_only(my_addr(strap), d, ok, rel);
    chk(ok && d == 8'h96, "R6 receive after write of reg 6", d, 8'h96);

    // R8, R11: mismatched address, command not acknowledged
    w0 = we_cnt;
    do_start(); send_byte({my_addr(3'd2), 1'b0}, ack);
    chk(ack == 1'b0, "R8 mismatch not acked", ack, 0);
    send_byte(8'h02, ack);
    chk(ack == 1'b0, "R8 command after mismatch not acked", ack, 0);
    send_byte(8'hFF, ack); do_stop();
    chk(we_cnt == w0, "R8 no write after mismatch", we_cnt - w0, 0);
    recv_only(my_addr(strap), d, ok, rel);
    chk(d == expv[6], "R11 pointer kept after unacked command", d, expv[6]);
    read_reg(my_addr(strap), 8'd2, d, ok, rel);
    chk(d == expv[2], "R8 reg 2 unchanged", d, expv[2]);

    // R9: repeated START in the middle of a command byte
    do_start(); send_byte({my_addr(strap), 1'b0}, ack);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    write_reg(my_addr(strap), 8'd1, 8'h3C, ok);
    expv[1] = 8'h3C;
    chk(ok, "R9 restart accepted", ok, 1);
    read_reg(my_addr(strap), 8'd1, d, ok, rel);
    chk(d == 8'h3C, "R9 write after mid-byte restart", d, 8'h3C);

    // R7: extra clocks after host NACK read back all ones
    do_start(); send_byte({my_addr(strap), 1'b1}, ack); recv_byte(d, rel);
    recv_byte(d, rel); do_stop();
    chk(d == 8'hFF && rel == 1'b1, "R7 stays released after NACK", d, 8'hFF);

    // R2: after STOP, clocked bits are ignored
    w0 = we_cnt;
    send_byte({my_addr(strap), 1'b0}, ack);
    chk(ack == 1'b0, "R2 no ack after STOP", ack, 0);
    send_byte(8'h04, ack); send_byte(8'h11, ack);
    chk(we_cnt == w0, "R2 no write after STOP", we_cnt - w0, 0);
    do_stop();
    recv_only(my_addr(strap), d, ok, rel);
    chk(d == expv[1], "R2 pointer untouched after STOP", d, expv[1]);

    summary();
    $finish;
  end
endmodule